// File: doc/BRIEF.md
# CAN Controller Mode and Resynchronization Control

This block holds the CPU-visible mode byte of a CAN controller and sequences its operating modes. It owns the soft-reset state, the synchronized flag, the sleep request/acknowledge handshake and the timer-link enable. Bit timing, framing, filtering and error counting live elsewhere. They reach this block only as strobes: a sampled bit with its level, a bus-activity indication and the bus-off state.

While soft reset is active, the block grants CPU writes to the configuration registers of the controller. At any other time those writes are dropped. Soft reset is also exported as a level, so that neighbouring flag and control registers return to their reset values. Entering soft reset emits a one-cycle abort pulse to the transfer logic. Once the CPU releases soft reset, the block counts runs of recessive bits to decide when the node has joined the bus. A bus-off node must see a much longer recovery sequence.

Sleep is requested by the CPU and granted only while the bus is idle. Bus traffic during sleep wakes the controller and raises a one-cycle wakeup interrupt. A wakeup made by the CPU raises no interrupt.

Top module: `can_mode_ctrl`

## Requirements
- R1: After hardware reset the mode byte reads 0x01: only soft reset (bit 0) is set, and `soft_rst` is high.
- R2: A write with bit 0 = 1 makes bit 0 read 1 and bit 4 (synchronized) read 0 from the next cycle. If soft reset was previously clear, `xfer_abort` pulses high for exactly that one cycle.
- R3: A write with bit 0 = 1 forces bits 1 (sleep request), 2 (sleep acknowledge), 3 (timer link) and 4 to 0, whatever the written data. These bits stay 0 while soft reset is held.
- R4: In the same cycle, `cfg_wr_en[i]` equals `cfg_wr_req[i]` while bit 0 reads 1, and is 0 for every i otherwise.
- R5: With soft reset clear and `bus_off` low, bit 4 sets on the cycle after the 11th consecutive `bit_strobe` that has `bit_recessive` = 1. Any dominant strobe restarts the run.
- R6: With soft reset clear and `bus_off` high, bit 4 sets only after 128 complete runs of 11 recessive strobes, and stays 0 after 127 runs.
- R7: Bit 2 sets one cycle after a cycle in which bit 1 is 1, soft reset is clear and `bus_active` is low. It does not set while `bus_active` is high.
- R8: While bit 2 is 1, a cycle with `bus_active` high clears bit 2 in the next cycle. In that same cycle `wake_irq` is high, for that single cycle only.
- R9: A CPU write with bit 2 = 0 clears bit 2 in the next cycle, and `wake_irq` stays low.
- R10: `tmr_out` equals `tmr_src` while bit 3 is 1 and is 0 while bit 3 is 0.
- R11: Bits 7 to 5 always read 0. Written values of bits 7 to 4, and a written 1 in bit 2, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ctl_wr | input | 1 | CPU write strobe for the mode byte |
| ctl_wdata | input | 8 | CPU write data for the mode byte |
| ctl_rdata | output | 8 | Mode byte read value |
| cfg_wr_req | input | NUM_CFG | CPU write strobes, one per configuration register |
| cfg_wr_en | output | NUM_CFG | Write enables passed on to the configuration registers |
| bit_strobe | input | 1 | One-cycle strobe per sampled bus bit |
| bit_recessive | input | 1 | Level of the sampled bit, 1 = recessive |
| bus_active | input | 1 | High while activity is detected on the bus |
| bus_off | input | 1 | Node is in the bus-off state |
| tmr_src | input | 1 | Timer signal from the controller core |
| tmr_out | output | 1 | Timer signal routed to the on-chip timer |
| soft_rst | output | 1 | Soft reset level for neighbouring registers |
| xfer_abort | output | 1 | One-cycle pulse that aborts an ongoing transfer |
| wake_irq | output | 1 | One-cycle wakeup interrupt pulse |

## Verification
The registered results (mode byte bits, `xfer_abort`, `wake_irq`) are due one clock after the edge that samples the write, strobe or bus-activity input. The gated write enables and the timer output follow their inputs in the same cycle. The driver changes inputs on the falling edge and queues each expectation at the following falling edge, after exactly one rising edge. The monitor compares the expectation 1 ns later. Multi-cycle behaviour such as sleep entry is checked by stepping whole cycles before the expectation is queued, so every expected value lines up with the register count on its path.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   localparam int CTL_W    = 8;
   localparam int B_SRST   = 0;
   localparam int B_SLPRQ  = 1;
   localparam int B_SLPAK  = 2;
   localparam int B_TLNK   = 3;
   localparam int B_SYNC   = 4;
endpackage

// File: rtl/can_ctl_reg.sv
module can_ctl_reg
   import can_mode_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output logic             srst,
   output logic             enter_srst,
   output logic             tlnk,
   output logic             slprq,
   output logic             abort,
   output logic             slpak_clr
);
   assign enter_srst = wr & wdata[B_SRST];
   assign slpak_clr  = wr & ~wdata[B_SLPAK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst  <= 1'b1;
         tlnk  <= 1'b0;
         slprq <= 1'b0;
         abort <= 1'b0;
      end else begin
         abort <= 1'b0;
         if (wr) begin
            if (wdata[B_SRST]) begin
               srst  <= 1'b1;
               tlnk  <= 1'b0;
               slprq <= 1'b0;
               abort <= ~srst;
            end else begin
               srst  <= 1'b0;
               tlnk  <= wdata[B_TLNK];
               slprq <= wdata[B_SLPRQ];
            end
         end
      end
   end
endmodule

// File: rtl/can_sync_track.sv
module can_sync_track #(
   parameter int RUN_LEN = 11,
   parameter int SEQ_N   = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic strobe,
   input  logic recessive,
   input  logic bus_off,
   output logic sync
);
   localparam int RUN_W = $clog2(RUN_LEN + 1);
   localparam int SEQ_W = $clog2(SEQ_N + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
   localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_N - 1);

   logic [RUN_W-1:0] run_q;
   logic [SEQ_W-1:0] seq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         seq_q <= '0;
         sync  <= 1'b0;
      end else if (hold) begin
         run_q <= '0;
         seq_q <= '0;
         sync  <= 1'b0;
      end else if (strobe && !sync) begin
         if (!recessive) begin
            run_q <= '0;
         end else if (run_q == RUN_LAST) begin
            run_q <= '0;
            if (!bus_off || seq_q == SEQ_LAST) begin
               sync  <= 1'b1;
               seq_q <= '0;
            end else begin
               seq_q <= seq_q + 1'b1;
            end
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/can_sleep_hs.sv
module can_sleep_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic req,
   input  logic cpu_clr,
   input  logic bus_active,
   output logic ack,
   output logic wake_irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack      <= 1'b0;
         wake_irq <= 1'b0;
      end else begin
         wake_irq <= 1'b0;
         if (hold || cpu_clr) begin
            ack <= 1'b0;
         end else if (ack) begin
            if (bus_active) begin
               ack      <= 1'b0;
               wake_irq <= 1'b1;
            end
         end else if (req && !bus_active) begin
            ack <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter int NUM_CFG = 12,
   parameter int RUN_LEN = 11,
   parameter int SEQ_N   = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic [CTL_W-1:0]   ctl_wdata,
   output logic [CTL_W-1:0]   ctl_rdata,
   input  logic [NUM_CFG-1:0] cfg_wr_req,
   output logic [NUM_CFG-1:0] cfg_wr_en,
   input  logic               bit_strobe,
   input  logic               bit_recessive,
   input  logic               bus_active,
   input  logic               bus_off,
   input  logic               tmr_src,
   output logic               tmr_out,
   output logic               soft_rst,
   output logic               xfer_abort,
   output logic               wake_irq
);
   if (NUM_CFG < 1)  begin : g_bad_cfg  $error("NUM_CFG must be at least 1");  end
   if (RUN_LEN < 2)  begin : g_bad_run  $error("RUN_LEN must be at least 2");  end
   if (SEQ_N < 1)    begin : g_bad_seq  $error("SEQ_N must be at least 1");    end

   logic srst, enter_srst, tlnk, slprq, slpak_clr, slpak, sync;
   logic hold;

   can_ctl_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (ctl_wr),
      .wdata      (ctl_wdata),
      .srst       (srst),
      .enter_srst (enter_srst),
      .tlnk       (tlnk),
      .slprq      (slprq),
      .abort      (xfer_abort),
      .slpak_clr  (slpak_clr)
   );

   assign hold = srst | enter_srst;

   can_sync_track #(.RUN_LEN(RUN_LEN), .SEQ_N(SEQ_N)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (hold),
      .strobe    (bit_strobe),
      .recessive (bit_recessive),
      .bus_off   (bus_off),
      .sync      (sync)
   );

   can_sleep_hs u_sleep (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (hold),
      .req        (slprq),
      .cpu_clr    (slpak_clr),
      .bus_active (bus_active),
      .ack        (slpak),
      .wake_irq   (wake_irq)
   );

   for (genvar i = 0; i < NUM_CFG; i++) begin : g_gate
      assign cfg_wr_en[i] = cfg_wr_req[i] & srst;
   end

   always_comb begin
      ctl_rdata          = '0;
      ctl_rdata[B_SRST]  = srst;
      ctl_rdata[B_SLPRQ] = slprq;
      ctl_rdata[B_SLPAK] = slpak;
      ctl_rdata[B_TLNK]  = tlnk;
      ctl_rdata[B_SYNC]  = sync;
   end

   assign tmr_out  = tlnk & tmr_src;
   assign soft_rst = srst;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
   parameter int NUM_CFG = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ctl_wr,
   input logic [7:0]         ctl_wdata,
   input logic [7:0]         ctl_rdata,
   input logic [NUM_CFG-1:0] cfg_wr_en,
   input logic               bit_strobe,
   input logic               bit_recessive,
   input logic               bus_active,
   input logic               tmr_out,
   input logic               xfer_abort,
   input logic               wake_irq
);
   AST_SET_SRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[0]) |=> (ctl_rdata[0] && !ctl_rdata[4])); // R2
   AST_ABORT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_abort |-> (ctl_rdata[0] && !$past(ctl_rdata[0]))); // R2
   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[0] |-> (ctl_rdata[4:1] == 4'b0)); // R3
   AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[0] |-> (cfg_wr_en == '0)); // R4
   AST_SYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_rdata[4]) |-> $past(bit_strobe && bit_recessive)); // R5
   AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_rdata[2]) |-> $past(!bus_active)); // R7
   AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq); // R8
   AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> (!ctl_rdata[2] && $past(ctl_rdata[2]) && $past(bus_active))); // R8
   AST_TMR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[3] |-> !tmr_out); // R10
   AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[7:5] == 3'b0); // R11
endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(.NUM_CFG(NUM_CFG)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_wr        (ctl_wr),
   .ctl_wdata     (ctl_wdata),
   .ctl_rdata     (ctl_rdata),
   .cfg_wr_en     (cfg_wr_en),
   .bit_strobe    (bit_strobe),
   .bit_recessive (bit_recessive),
   .bus_active    (bus_active),
   .tmr_out       (tmr_out),
   .xfer_abort    (xfer_abort),
   .wake_irq      (wake_irq)
);

// File: tb/can_mode_ctrl_bench.sv
`timescale 1ns/1ps
module can_mode_ctrl_bench;
   localparam int NCFG = 12;
   localparam int W_RD = 0, W_CFG = 1, W_WAKE = 2, W_TMR = 3, W_ABT = 4, W_SRST = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0, ctl_rdata;
   logic [NCFG-1:0] cfg_wr_req = '0, cfg_wr_en;
   logic bit_strobe = 1'b0, bit_recessive = 1'b1, bus_active = 1'b0, bus_off = 1'b0;
   logic tmr_src = 1'b0, tmr_out, soft_rst, xfer_abort, wake_irq;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      string       req;
      int          what;
      logic [15:0] exp;
   } item_t;
   item_t q[$];

   always #4 clk = ~clk;

   can_mode_ctrl u_can_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .cfg_wr_req(cfg_wr_req), .cfg_wr_en(cfg_wr_en),
      .bit_strobe(bit_strobe), .bit_recessive(bit_recessive),
      .bus_active(bus_active), .bus_off(bus_off), .tmr_src(tmr_src),
      .tmr_out(tmr_out), .soft_rst(soft_rst), .xfer_abort(xfer_abort),
      .wake_irq(wake_irq)
   );

   function automatic logic [15:0] actual(int w);
      case (w)
         W_RD:    return {8'h0, ctl_rdata};
         W_CFG:   return {4'h0, cfg_wr_en};
         W_WAKE:  return {15'h0, wake_irq};
         W_TMR:   return {15'h0, tmr_out};
         W_ABT:   return {15'h0, xfer_abort};
         W_SRST:  return {15'h0, soft_rst};
         default: return 16'h0;
      endcase
   endfunction

   // monitor: compares queued expectations 1 ns after each falling edge
   initial begin
      item_t it;
      logic [15:0] act;
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            it  = q.pop_front();
            act = actual(it.what);
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: signal %0d actual 0x%0h expected 0x%0h", it.req, it.what, act, it.exp);
            end
         end
      end
   end

   task automatic expect_v(string req, int what, logic [15:0] exp);
      item_t it;
      it.req = req; it.what = what; it.exp = exp;
      q.push_back(it);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic cpu_write(logic [7:0] d);
      ctl_wr = 1'b1; ctl_wdata = d;
      tick();
      ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic send_bit(logic rec);
      bit_strobe = 1'b1; bit_recessive = rec;
      tick();
      bit_strobe = 1'b0; bit_recessive = 1'b1;
   endtask

   task automatic send_run(int n);
      for (int k = 0; k < n; k++) send_bit(1'b1);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      expect_v("R1", W_RD, 16'h01);
      expect_v("R1", W_SRST, 16'h1);
      // R4 gate open in soft reset
      cfg_wr_req = 12'hA5A;
      expect_v("R4", W_CFG, 16'h0A5A);
      tick();

      // leave soft reset, timer link on
      cpu_write(8'h08);
      expect_v("R10", W_RD, 16'h08);
      cfg_wr_req = '1;
      tmr_src = 1'b1;
      expect_v("R4", W_CFG, 16'h0000);
      expect_v("R10", W_TMR, 16'h1);
      tick();
      cfg_wr_req = '0;

      // R5: dominant restarts the run
      send_run(10);
      expect_v("R5", W_RD, 16'h08);
      send_bit(1'b0);
      send_run(10);
      expect_v("R5", W_RD, 16'h08);
      send_bit(1'b1);
      expect_v("R5", W_RD, 16'h18);
      tick();

      // R7: sleep request with bus active is not granted
      bus_active = 1'b1;
      cpu_write(8'h0A);
      expect_v("R7", W_RD, 16'h1A);
      tick();
      expect_v("R7", W_RD, 16'h1A);
      bus_active = 1'b0;
      tick();
      expect_v("R7", W_RD, 16'h1E);
      // R8: bus activity wakes with a single pulse
      bus_active = 1'b1;
      tick();
      expect_v("R8", W_RD, 16'h1A);
      expect_v("R8", W_WAKE, 16'h1);
      bus_active = 1'b0;
      tick();
      expect_v("R8", W_WAKE, 16'h0);
      expect_v("R8", W_RD, 16'h1E);

      // R9: CPU wakeup without interrupt (bit 2 written 0)
      cpu_write(8'h08);
      expect_v("R9", W_RD, 16'h18);
      expect_v("R9", W_WAKE, 16'h0);
      tick();
      expect_v("R9", W_WAKE, 16'h0);

      // R11: writing 1 to bit 2 does not set sleep acknowledge
      cpu_write(8'h0C);
      expect_v("R11", W_RD, 16'h18);

      // R2/R3: enter soft reset with other bits written 1
      cpu_write(8'h0F);
      expect_v("R3", W_RD, 16'h01);
      expect_v("R2", W_ABT, 16'h1);
      tmr_src = 1'b1;
      expect_v("R10", W_TMR, 16'h0);
      tick();
      expect_v("R2", W_ABT, 16'h0);
      // a second soft-reset write gives no abort pulse
      cpu_write(8'h01);
      expect_v("R2", W_ABT, 16'h0);

      // R11: upper bits and sync bit are not writable
      cpu_write(8'hF0);
      expect_v("R11", W_RD, 16'h00);
      tmr_src = 1'b0;

      // R6: bus-off recovery needs 128 runs
      bus_off = 1'b1;
      send_run(5);
      send_bit(1'b0);
      for (int r = 0; r < 127; r++) send_run(11);
      expect_v("R6", W_RD, 16'h00);
      send_run(10);
      expect_v("R6", W_RD, 16'h00);
      send_bit(1'b1);
      expect_v("R6", W_RD, 16'h10);
      tick();
      bus_off = 1'b0;

      // R2: soft reset clears sync at once
      cpu_write(8'h01);
      expect_v("R2", W_RD, 16'h01);
      expect_v("R2", W_ABT, 16'h1);
      tick();
      tick();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule